// File: doc/BRIEF.md
# Double-Buffered NCO Phase Generator with Hop Control

This block produces the phase word that drives a downstream sine/cosine stage. Software writes a 32-bit tuning word as two 16-bit halves. The halves land in a staging copy and never go straight to the word the oscillator uses. The staged word is promoted to the live word in one of three ways: when the channel comes out of sleep, at the end of a countdown started by a sync event, or at once when the countdown length is programmed to 1.

A 32-bit phase accumulator adds the live word on every cycle in which the sample enable is high. The upper 16 bits of the accumulator, plus a programmable 16-bit phase offset, form the output. A sync event can come from a software strobe or from one of four sync pins chosen by a control field. The countdown it starts ends in a frequency hop. A hop either keeps the accumulated phase or clears the accumulator, as a control bit selects.

Top module: `nco_hop_phase`

Register map (write only, 16-bit data):
- address 0: low half of the staged word
- address 1: high half of the staged word
- address 2: phase offset
- address 3: countdown length
- address 4: control word. Bits [1:0] pick the sync pin. Bit 2 is hop-clear.

Writes to any other address have no effect.

## Requirements
- R1: After reset, phase_out is 0, and the live word, the staged word, the offset, the countdown length and the control word are all 0.
- R2: A write to address 0 or 1 changes only the staged word. While the countdown length is not 1, the accumulator step is unchanged until a transfer. Writes to addresses 5 to 7 change nothing.
- R3: In a cycle with samp_en high and sleep low, the accumulator advances by the live word modulo 2^32. With samp_en low it holds its value.
- R4: phase_out equals accumulator bits [31:16] plus the offset, modulo 2^16. A write to address 2 takes effect on the next cycle.
- R5: While sleep is high, the accumulator holds, sync events are ignored and any pending countdown is cancelled. In the first cycle with sleep low after a cycle with sleep high, the live word is loaded from the staged word.
- R6: A sync event with a nonzero countdown length loads the counter with that length. The counter then decrements on each samp_en while it is above 1. In the cycle after it holds 1, the live word takes the staged value. A countdown length of 0 makes sync events ignored.
- R7: With a countdown length of 1, a write to address 0 or 1 updates the live word in the next cycle.
- R8: When a countdown transfer occurs with hop-clear (control bit 2) set, the accumulator becomes 0 in that cycle. With hop-clear at 0, the accumulator keeps its phase.
- R9: The sync pin whose index equals control bits [1:0] triggers a sync event. The other three pins are ignored. The software strobe always triggers one.
- R10: A sync event while a countdown is pending restarts the countdown from the programmed length. A sync event in the same cycle that the counter holds 1 suppresses that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| sleep | input | 1 | Channel sleep; high freezes the channel |
| soft_sync | input | 1 | Software sync strobe |
| sync_pins | input | 4 | Sync pins; one selected by control bits [1:0] |
| samp_en | input | 1 | Sample enable; advances accumulator and countdown |
| phase_out | output | 16 | Phase word for the sine/cosine stage |

## Verification
The bench builds the block with its default widths: 16-bit register halves, a 16-bit countdown and four sync pins. It programs countdown lengths of 1 and 3, so a full countdown, a countdown restarted mid-way and an immediate transfer each complete within a handful of cycles. A tuning word of 0xF0000000 wraps the accumulator within a few samples.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADR_FREQ_LO = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_FREQ_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_OFFSET  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_HOLD    = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd4;
endpackage

// File: rtl/nco_sync_sel.sv
module nco_sync_sel #(
    parameter int NUM_SYNC = 4,
    localparam int SEL_W = $clog2(NUM_SYNC)
) (
    input  logic                soft_sync,
    input  logic [NUM_SYNC-1:0] sync_pins,
    input  logic [SEL_W-1:0]    sel,
    output logic                sync_ev
);
    logic [NUM_SYNC-1:0] pin_hit;

    for (genvar i = 0; i < NUM_SYNC; i++) begin : g_pin
        assign pin_hit[i] = sync_pins[i] && (sel == SEL_W'(i));
    end

    always_comb begin
        sync_ev = soft_sync || (|pin_hit);
    end
endmodule

// File: rtl/nco_freq_ctrl.sv
module nco_freq_ctrl
    import nco_pkg::*;
#(
    parameter int HALF_W   = 16,
    parameter int HOLD_W   = 16,
    parameter int OFF_W    = 16,
    parameter int NUM_SYNC = 4,
    localparam int FREQ_W  = 2 * HALF_W,
    localparam int SEL_W   = $clog2(NUM_SYNC),
    localparam int CLR_BIT = SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              sleep,
    input  logic              sync_ev,
    input  logic              samp_en,
    output logic [FREQ_W-1:0] active_o,
    output logic [OFF_W-1:0]  offset_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              acc_clr_o
);
    typedef struct packed {
        logic [FREQ_W-1:0] shadow;
        logic [FREQ_W-1:0] active;
        logic [OFF_W-1:0]  offset;
        logic [HOLD_W-1:0] holdoff;
        logic [HOLD_W-1:0] cnt;
        logic [SEL_W-1:0]  sel;
        logic              hop_clr;
        logic              sleep;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;
    logic     freq_wr;
    logic     wake;
    logic     imm_wr;

    always_comb begin
        st_d      = st_q;
        acc_clr_o = 1'b0;
        freq_wr   = wr_en && (wr_addr == ADR_FREQ_LO || wr_addr == ADR_FREQ_HI);
        wake      = st_q.sleep && !sleep;
        imm_wr    = freq_wr && (st_q.holdoff == HOLD_W'(1));
        if (wr_en) begin
            case (wr_addr)
                ADR_FREQ_LO: st_d.shadow[HALF_W-1:0]      = wr_data;
                ADR_FREQ_HI: st_d.shadow[FREQ_W-1:HALF_W] = wr_data;
                ADR_OFFSET:  st_d.offset  = wr_data[OFF_W-1:0];
                ADR_HOLD:    st_d.holdoff = wr_data[HOLD_W-1:0];
                ADR_CTRL: begin
                    st_d.sel     = wr_data[SEL_W-1:0];
                    st_d.hop_clr = wr_data[CLR_BIT];
                end
                default: ;
            endcase
        end
        st_d.sleep = sleep;
        if (sleep) begin
            st_d.cnt = '0;
        end else begin
            if (wake) st_d.active = st_q.shadow;
            if (sync_ev && st_q.holdoff != '0) begin
                st_d.cnt = st_q.holdoff;
            end else if (st_q.cnt == HOLD_W'(1)) begin
                st_d.active = st_q.shadow;
                st_d.cnt    = '0;
                acc_clr_o   = st_q.hop_clr;
            end else if (st_q.cnt > HOLD_W'(1) && samp_en) begin
                st_d.cnt = st_q.cnt - HOLD_W'(1);
            end
            if (imm_wr) st_d.active = st_d.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign offset_o = st_q.offset;
    assign sel_o    = st_q.sel;

    // R5: sleep cancels any pending countdown
    p_sleep_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (st_q.cnt == '0));

    // R5: leaving sleep promotes the staged word
    p_wake_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !imm_wr) |=> (st_q.active == $past(st_q.shadow)));

    // R6: accepted sync loads the programmed countdown length
    p_sync_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ev && !sleep && st_q.holdoff != '0) |=> (st_q.cnt == $past(st_q.holdoff)));

    // R2: live word stays put outside the three transfer paths
    p_live_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake && st_q.cnt != HOLD_W'(1) && !imm_wr) |=> $stable(st_q.active));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic [FREQ_W-1:0]  step,
    input  logic               clr,
    input  logic [PHASE_W-1:0] offset,
    output logic [PHASE_W-1:0] phase_out
);
    logic [FREQ_W-1:0] acc_q, acc_d;

    always_comb begin
        acc_d = acc_q;
        if (clr)          acc_d = '0;
        else if (step_en) acc_d = acc_q + step;
        phase_out = acc_q[FREQ_W-1 -: PHASE_W] + offset;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R3: accumulator holds without an enable
    p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !clr) |=> $stable(acc_q));

    // R3: one enabled sample adds exactly one step
    p_acc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !clr) |=> (acc_q == $past(acc_q) + $past(step)));

    // R8: clearing hop zeroes the accumulator
    p_hop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));
endmodule

// File: rtl/nco_hop_phase.sv
module nco_hop_phase
    import nco_pkg::*;
#(
    parameter int HALF_W   = 16,
    parameter int HOLD_W   = 16,
    parameter int PHASE_W  = 16,
    parameter int NUM_SYNC = 4,
    localparam int FREQ_W  = 2 * HALF_W,
    localparam int SEL_W   = $clog2(NUM_SYNC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic                sleep,
    input  logic                soft_sync,
    input  logic [NUM_SYNC-1:0] sync_pins,
    input  logic                samp_en,
    output logic [PHASE_W-1:0]  phase_out
);
    logic [FREQ_W-1:0]  active;
    logic [PHASE_W-1:0] offset;
    logic [SEL_W-1:0]   sel;
    logic               sync_ev;
    logic               acc_clr;
    logic               step_en;

    assign step_en = samp_en && !sleep;

    nco_sync_sel #(.NUM_SYNC(NUM_SYNC)) u_sync (
        .soft_sync (soft_sync),
        .sync_pins (sync_pins),
        .sel       (sel),
        .sync_ev   (sync_ev)
    );

    nco_freq_ctrl #(
        .HALF_W   (HALF_W),
        .HOLD_W   (HOLD_W),
        .OFF_W    (PHASE_W),
        .NUM_SYNC (NUM_SYNC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sleep     (sleep),
        .sync_ev   (sync_ev),
        .samp_en   (samp_en),
        .active_o  (active),
        .offset_o  (offset),
        .sel_o     (sel),
        .acc_clr_o (acc_clr)
    );

    nco_phase_acc #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .step      (active),
        .clr       (acc_clr),
        .offset    (offset),
        .phase_out (phase_out)
    );
endmodule

// File: tb/sim_nco_hop_phase.sv
module sim_nco_hop_phase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sleep = 1'b0;
    logic        soft_sync = 1'b0;
    logic [3:0]  sync_pins = '0;
    logic        samp_en = 1'b0;
    logic [15:0] phase_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    // reference state
    logic [31:0] m_sh = '0, m_act = '0, m_acc = '0;
    logic [15:0] m_off = '0, m_hold = '0, m_cnt = '0;
    logic [1:0]  m_sel = '0;
    logic        m_clr = 1'b0, m_slp = 1'b0;

    always #4 clk = ~clk;

    nco_hop_phase u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sleep(sleep), .soft_sync(soft_sync),
        .sync_pins(sync_pins), .samp_en(samp_en), .phase_out(phase_out)
    );

    task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d,
                        input logic slp, input logic sf, input logic [3:0] pn,
                        input logic en, input string tag);
        logic [31:0] n_sh, n_act, n_acc;
        logic [15:0] n_off, n_hold, n_cnt;
        logic [1:0]  n_sel;
        logic        n_clr, sync, fw;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; sleep = slp;
        soft_sync = sf; sync_pins = pn; samp_en = en;
        n_sh = m_sh; n_act = m_act; n_acc = m_acc; n_off = m_off;
        n_hold = m_hold; n_cnt = m_cnt; n_sel = m_sel; n_clr = m_clr;
        fw = we && (a == 3'd0 || a == 3'd1);
        if (we) begin
            if (a == 3'd0) n_sh[15:0] = d;
            if (a == 3'd1) n_sh[31:16] = d;
            if (a == 3'd2) n_off = d;
            if (a == 3'd3) n_hold = d;
            if (a == 3'd4) begin n_sel = d[1:0]; n_clr = d[2]; end
        end
        sync = sf || pn[m_sel];
        if (slp) begin
            n_cnt = '0;
        end else begin
            if (m_slp) n_act = m_sh;
            if (en) n_acc = m_acc + m_act;
            if (sync && m_hold != 0) n_cnt = m_hold;
            else if (m_cnt == 1) begin
                n_act = m_sh; n_cnt = '0;
                if (m_clr) n_acc = '0;
            end else if (m_cnt > 1 && en) n_cnt = m_cnt - 1;
            if (fw && m_hold == 1) n_act = n_sh;
        end
        m_sh = n_sh; m_act = n_act; m_acc = n_acc; m_off = n_off;
        m_hold = n_hold; m_cnt = n_cnt; m_sel = n_sel; m_clr = n_clr; m_slp = slp;
        exp_q.push_back(m_acc[31:16] + m_off);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input logic en, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 4'h0, en, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 1'b0, 4'h0, 1'b1, tag);
    endtask

    // monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (phase_out !== e) begin
                n_bad++;
                $display("FAIL %s phase_out actual=%h expected=%h", t, phase_out, e);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(3, 1'b1, "R1");
        // staged word only
        wr(3'd0, 16'h0000, "R2");
        wr(3'd1, 16'h0100, "R2");
        idle(3, 1'b1, "R2");
        // sleep then wake loads staged word
        step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 4'h0, 1'b1, "R5");
        step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 4'h0, 1'b1, "R5");
        idle(4, 1'b1, "R3");
        for (int i = 0; i < 6; i++) idle(1, logic'(i % 2), "R3");
        // offset
        wr(3'd2, 16'h8000, "R4");
        idle(2, 1'b1, "R4");
        // countdown of 3
        wr(3'd3, 16'd3, "R6");
        wr(3'd1, 16'h0200, "R2");
        idle(3, 1'b1, "R2");
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1, 4'h0, 1'b1, "R6");
        for (int i = 0; i < 7; i++) idle(1, logic'(i % 2), "R6");
        // pin 2 selected, hop-clear on
        wr(3'd4, 16'h0006, "R8");
        wr(3'd1, 16'h0300, "R8");
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 4'b1011, 1'b1, "R9");
        idle(4, 1'b1, "R9");
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 4'b0100, 1'b1, "R9");
        idle(5, 1'b1, "R8");
        // restart of a pending countdown
        wr(3'd1, 16'h0400, "R10");
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1, 4'h0, 1'b1, "R10");
        idle(1, 1'b1, "R10");
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1, 4'h0, 1'b1, "R10");
        idle(5, 1'b1, "R10");
        // immediate path and wrap
        wr(3'd4, 16'h0000, "R8");
        wr(3'd3, 16'd1, "R7");
        wr(3'd1, 16'hF000, "R7");
        idle(6, 1'b1, "R3");
        wr(3'd0, 16'h1234, "R7");
        idle(2, 1'b1, "R7");
        // sync ignored during sleep
        for (int i = 0; i < 3; i++) step(1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 4'hF, 1'b1, "R5");
        idle(4, 1'b1, "R5");
        // unmapped address
        step(1'b1, 3'd7, 16'hFFFF, 1'b0, 1'b0, 4'h0, 1'b1, "R2");
        idle(3, 1'b1, "R2");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule